// File: doc/BRIEF.md
# Class-Based Cache Slice Selector

This block decides which slice of a distributed last-level cache, spread over a grid of tiles, serves one access. Each request carries the requesting tile number, a flag marking the instruction-fetch path, a page-class flag (private or shared) and the physical address. The block returns the number of the tile whose slice must be probed. Private data stays in the requester's own slice. Shared data is spread evenly over every slice by a field of the address. Instructions are replicated over overlapping clusters of four neighbouring tiles, so that any instruction block lives exactly once in every cluster and one probe always finds it.

Tiles are numbered down columns: tile = column × ROWS + row. Every tile carries a two-bit rotation tag equal to (row + 2 × column) mod 4. The tag rises by one per step down a column and by two per step along a row, so a tile together with the tile below, the tile above and the tile to its right holds each tag exactly once. Every neighbour move wraps around the torus.

Requests enter on a valid/ready handshake and the answer leaves through a one-entry output register that has its own valid/ready handshake. A request is taken when `req_valid` and `req_ready` are both high. An answer is delivered when `rsp_valid` and `rsp_ready` are both high. While the consumer holds `rsp_ready` low, the answer stays put and no new request is taken. The grid shape and the address field positions are parameters.

Top module: `slice_selector`

## Requirements
- R1: A taken data request (`req_ifetch`=0) with `req_shared`=0 answers with `rsp_tile` equal to `req_tile`.
- R2: A taken data request with `req_shared`=1 answers with the tile number held in address bits [20:16]. The address layout is tag | slice number | 10 index bits | 6 offset bits.
- R3: A request with `req_ifetch`=1 follows the instruction rule whatever the value of `req_shared`.
- R4: The rotation tag of a tile is (row + 2 × column) mod 4, where row = tile mod 8 and column = tile div 8. Tile 0 has tag 0, tile 1 has tag 1, tile 8 has tag 2 and tile 16 has tag 0. Each cluster {self, below, above, right} covers all four tags.
- R5: For an instruction, the target tag is address bits [7:6]. With d = (target − own tag) mod 4, the answer is: the requester itself when d=0, the next row down when d=1, the next column to the right when d=2, and the row above when d=3. Rows and columns wrap.
- R6: The answer to a taken request is presented with `rsp_valid`=1 from the first clock edge after it is taken.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_tile` holds its value and `req_ready` is 0. `req_ready` is 1 whenever the output register is empty or is being emptied in the same cycle.
- R8: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_tile | input | 5 | Requesting tile number |
| req_ifetch | input | 1 | Access comes from the instruction-fetch path |
| req_shared | input | 1 | Page class: 1 shared, 0 private |
| req_addr | input | 32 | Physical address |
| rsp_valid | output | 1 | Destination available |
| rsp_ready | input | 1 | Consumer takes the destination |
| rsp_tile | output | 5 | Tile whose slice serves the access |

## Verification
The output register can be drained and reloaded in the same cycle. The consumer takes the old answer while the next request is taken, and only the ready path allows that overlap. The bench provokes it with back-to-back streams of mixed private, shared and instruction requests while `rsp_ready` toggles at random. It judges by the scoreboard, which expects every destination exactly once and in order, and by checking that a stalled answer stays equal to the head of the queue until it is taken.

// File: rtl/slice_sel_pkg.sv
package slice_sel_pkg;
  localparam int unsigned RID_W   = 2;
  localparam int unsigned CLUSTER = 4;

  typedef enum logic [1:0] {
    CLS_PRIVATE = 2'd0,
    CLS_SHARED  = 2'd1,
    CLS_INSTR   = 2'd2
  } access_class_e;

  typedef enum logic [1:0] {
    HOP_SELF  = 2'd0,
    HOP_DOWN  = 2'd1,
    HOP_RIGHT = 2'd2,
    HOP_UP    = 2'd3
  } cluster_hop_e;
endpackage

// File: rtl/sel_class_decode.sv
module sel_class_decode
  import slice_sel_pkg::*;
(
  input  logic          is_ifetch,
  input  logic          is_shared,
  output access_class_e cls
);
  // The fetch path overrides the page class.
  always_comb begin
    if (is_ifetch)      cls = CLS_INSTR;
    else if (is_shared) cls = CLS_SHARED;
    else                cls = CLS_PRIVATE;
  end
endmodule

// File: rtl/sel_tile_coord.sv
module sel_tile_coord
  import slice_sel_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 4,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned TILE_W = ROW_W + COL_W
) (
  input  logic [TILE_W-1:0] tile,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [RID_W-1:0]  rid
);
  assign row = tile[ROW_W-1:0];
  assign col = tile[TILE_W-1:ROW_W];
  // (row + 2*col) mod 4: only col[0] matters for the row term.
  assign rid = row[RID_W-1:0] + {col[0], 1'b0};
endmodule

// File: rtl/sel_cluster_route.sv
module sel_cluster_route
  import slice_sel_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 4,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned TILE_W = ROW_W + COL_W
) (
  input  logic [TILE_W-1:0] home_tile,
  input  logic [RID_W-1:0]  target_rid,
  output logic [TILE_W-1:0] dest_tile
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [RID_W-1:0] own_rid;
  cluster_hop_e     hop;

  sel_tile_coord #(.ROWS(ROWS), .COLS(COLS)) u_coord (
    .tile (home_tile),
    .row  (row),
    .col  (col),
    .rid  (own_rid)
  );

  assign hop = cluster_hop_e'(target_rid - own_rid);

  // Power-of-two grid: natural width overflow is the torus wrap.
  always_comb begin
    unique case (hop)
      HOP_SELF:  dest_tile = home_tile;
      HOP_DOWN:  dest_tile = {col, row + ROW_W'(1)};
      HOP_UP:    dest_tile = {col, row - ROW_W'(1)};
      HOP_RIGHT: dest_tile = {col + COL_W'(1), row};
      default:   dest_tile = home_tile;
    endcase
  end
endmodule

// File: rtl/sel_out_stage.sv
module sel_out_stage #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end
endmodule

// File: rtl/slice_selector.sv
module slice_selector
  import slice_sel_pkg::*;
#(
  parameter int unsigned ROWS     = 8,
  parameter int unsigned COLS     = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 6,
  parameter int unsigned INDEX_W  = 10,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned COL_W     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned TILE_W    = ROW_W + COL_W,
  localparam int unsigned SLICE_LSB = OFFSET_W + INDEX_W,
  localparam int unsigned RID_LSB   = OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TILE_W-1:0] req_tile,
  input  logic              req_ifetch,
  input  logic              req_shared,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TILE_W-1:0] rsp_tile
);
  access_class_e     cls;
  logic [TILE_W-1:0] instr_tile;
  logic [TILE_W-1:0] shared_tile;
  logic [TILE_W-1:0] next_tile;
  logic              unused_addr;

  assign unused_addr = ^req_addr;

  sel_class_decode u_decode (
    .is_ifetch (req_ifetch),
    .is_shared (req_shared),
    .cls       (cls)
  );

  sel_cluster_route #(.ROWS(ROWS), .COLS(COLS)) u_route (
    .home_tile  (req_tile),
    .target_rid (req_addr[RID_LSB +: RID_W]),
    .dest_tile  (instr_tile)
  );

  assign shared_tile = req_addr[SLICE_LSB +: TILE_W];

  always_comb begin
    unique case (cls)
      CLS_INSTR:  next_tile = instr_tile;
      CLS_SHARED: next_tile = shared_tile;
      default:    next_tile = req_tile;
    endcase
  end

  sel_out_stage #(.W(TILE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (next_tile),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_tile)
  );
endmodule

// File: rtl/slice_selector_chk.sv
module slice_selector_chk #(
  parameter int unsigned ROWS     = 8,
  parameter int unsigned COLS     = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 6,
  parameter int unsigned INDEX_W  = 10,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned COL_W     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned TILE_W    = ROW_W + COL_W,
  localparam int unsigned SLICE_LSB = OFFSET_W + INDEX_W,
  localparam int unsigned RID_LSB   = OFFSET_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [TILE_W-1:0] req_tile,
  input logic              req_ifetch,
  input logic              req_shared,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [TILE_W-1:0] rsp_tile
);
  function automatic int tag_of(int t);
    return ((t % ROWS) + 2 * (t / ROWS)) % 4;
  endfunction

  function automatic int move(int t, int dr, int dc);
    return ((t / ROWS + dc + COLS) % COLS) * ROWS + ((t % ROWS + dr + ROWS) % ROWS);
  endfunction

  function automatic bit in_cluster(int home, int t);
    return (t == home) || (t == move(home, 1, 0)) ||
           (t == move(home, -1, 0)) || (t == move(home, 0, 1));
  endfunction

  logic take;
  assign take = req_valid && req_ready;

  // R4: every cluster holds each rotation tag once
  initial begin
    for (int t = 0; t < ROWS * COLS; t++) begin
      logic [3:0] seen;
      seen = '0;
      seen[tag_of(t)]             = 1'b1;
      seen[tag_of(move(t, 1, 0))]  = 1'b1;
      seen[tag_of(move(t, -1, 0))] = 1'b1;
      seen[tag_of(move(t, 0, 1))]  = 1'b1;
      a_r4_cluster_cover: assert ($countones(seen) == 4);
    end
  end

  a_r1_private_local: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_ifetch && !req_shared) |=> (rsp_valid && rsp_tile == $past(req_tile)));

  a_r2_shared_field: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_ifetch && req_shared) |=>
      (rsp_valid && rsp_tile == $past(req_addr[SLICE_LSB +: TILE_W])));

  a_r5_instr_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_ifetch) |=>
      (rsp_valid && tag_of(int'(rsp_tile)) == int'($past(req_addr[RID_LSB +: 2]))));

  a_r5_instr_near: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_ifetch) |=> in_cluster(int'($past(req_tile)), int'(rsp_tile)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tile)));

  a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r7_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
endmodule

bind slice_selector slice_selector_chk #(
  .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)
) u_chk (.*);

// File: tb/test_slice_selector.sv
`timescale 1ns/1ps
module test_slice_selector;
  typedef struct {
    int    tile;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_tile = '0;
  logic        req_ifetch = 1'b0;
  logic        req_shared = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [4:0]  rsp_tile;

  int   checks = 0;
  int   errors = 0;
  bit   stall_mode = 1'b0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  slice_selector i_slice_selector (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_tile(req_tile),
    .req_ifetch(req_ifetch), .req_shared(req_shared), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tile(rsp_tile)
  );

  function automatic int model(int t, bit ifetch, bit shared, logic [31:0] a);
    int row, col, own, d;
    row = t % 8; col = t / 8;
    if (ifetch) begin
      own = (row + 2 * col) % 4;
      d = (int'(a[7:6]) - own + 4) % 4;
      case (d)
        0: return t;
        1: return col * 8 + (row + 1) % 8;
        2: return ((col + 1) % 4) * 8 + row;
        default: return col * 8 + (row + 7) % 8;
      endcase
    end
    if (shared) return int'(a[20:16]);
    return t;
  endfunction

  function automatic logic [31:0] mk_addr(int slice, int rid);
    logic [31:0] a;
    a = $urandom;
    a[20:16] = slice[4:0];
    a[7:6] = rid[1:0];
    return a;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int t, bit ifetch, bit shared, logic [31:0] a, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_tile = t[4:0]; req_ifetch = ifetch;
    req_shared = shared; req_addr = a;
    forever begin
      #2;
      if (req_ready) begin
        e.tile = model(t, ifetch, shared, a); e.tag = tag;
        sb.push_back(e);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    rsp_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor: pops on transfer, peeks while stalled (R7 hold)
  always @(negedge clk) begin
    #3;
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) check(1'b0, "R6 unexpected response", int'(rsp_tile), -1);
      else if (rsp_ready) begin
        check(int'(rsp_tile) == sb[0].tile, sb[0].tag, int'(rsp_tile), sb[0].tile);
        void'(sb.pop_front());
      end else begin
        check(int'(rsp_tile) == sb[0].tile, "R7 hold", int'(rsp_tile), sb[0].tile);
        check(!req_ready, "R7 ready low while stalled", int'(req_ready), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    check(rsp_valid == 1'b0, "R8 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #3;
    check(rsp_valid == 1'b0, "R8 rsp_valid after reset", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R8 req_ready after reset", int'(req_ready), 1);

    // R6: single request, answer after one edge
    send(13, 0, 0, mk_addr(2, 1), "R1 private");
    idle(); #3;
    check(rsp_valid == 1'b1, "R6 latency", int'(rsp_valid), 1);
    check(int'(rsp_tile) == 13, "R6 R1 value", int'(rsp_tile), 13);

    // R1 / R2 across patterns
    send(0, 0, 0, mk_addr(31, 3), "R1 private tile0");
    send(31, 0, 0, mk_addr(5, 0), "R1 private tile31");
    send(4, 0, 1, mk_addr(0, 2), "R2 shared slice0");
    send(4, 0, 1, mk_addr(31, 2), "R2 shared slice31");
    send(20, 0, 1, mk_addr(17, 1), "R2 shared slice17");
    // R3: fetch wins over page class
    send(9, 1, 1, mk_addr(30, 3), "R3 ifetch shared page");
    send(9, 1, 0, mk_addr(30, 0), "R3 ifetch private page");
    // R4: known tags (target = own tag -> self)
    send(0, 1, 0, mk_addr(3, 0), "R4 tile0 tag0");
    send(1, 1, 0, mk_addr(3, 1), "R4 tile1 tag1");
    send(8, 1, 0, mk_addr(3, 2), "R4 tile8 tag2");
    send(16, 1, 0, mk_addr(3, 0), "R4 tile16 tag0");
    // R5: wrap corners
    send(7, 1, 0, mk_addr(1, 0), "R5 wrap down 7->0");
    send(0, 1, 0, mk_addr(1, 3), "R5 wrap up 0->7");
    send(24, 1, 0, mk_addr(1, 0), "R5 wrap right 24->0");
    idle();

    // R5 sweep: every tile, every target tag, back-to-back
    for (int t = 0; t < 32; t++)
      for (int r = 0; r < 4; r++)
        send(t, 1, 0, mk_addr(t, r), "R5 sweep");
    idle();

    // R7: mixed stream under random back-pressure
    stall_mode = 1'b1;
    for (int k = 0; k < 300; k++)
      send(int'($urandom % 32), ($urandom % 3) == 0, $urandom % 2,
           mk_addr(int'($urandom % 32), int'($urandom % 4)), "R7 stream");
    idle();
    repeat (50) @(negedge clk);
    stall_mode = 1'b0;
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R7 all drained", sb.size(), 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule